// File: doc/BRIEF.md
# Ping-Pong Bulk Endpoint Buffer Manager

This block keeps the bookkeeping for two 512-byte halves of a shared byte-addressed SRAM. The two halves carry one bulk data stream between a USB serial engine and an ATA data path. One side, the producer, fills a half while the other side, the consumer, empties the other half. A half that is full, or that the producer has closed early with a short final packet, passes to the consumer. The producer then moves on to the other half. The block gives each side the SRAM byte address for its current byte and a flag that says whether that side may move a byte in the current cycle. It also reports the write and read byte count of each half and which halves are waiting to be drained.

One registered direction bit assigns the roles. With direction 0 the USB engine produces and the ATA path consumes. With direction 1 the roles are reversed. Only one direction is ever buffered. A request to change direction waits until both halves are empty. When the change is applied, both halves are cleared and both pointers go back to half A. SRAM arbitration and the USB and ATA protocols are outside this block.

Top module: `pp_buf_mgr`

## Requirements
- R1: After reset the direction is 0, both halves are empty with zero counts, and the fill and drain pointers are on half A. So `usb_rdy_o`=1, `usb_addr_o`=0x100, `ata_rdy_o`=0 and `ata_addr_o`=0x100.
- R2: The producer address is the base of the half being filled plus that half's write count. Half A is based at 0x100 and half B at 0x300. The producer fills A first and then alternates between the halves.
- R3: The 512th byte accepted into a half closes it. The half's bit in `half_full_o` (bit 0 = A, bit 1 = B) goes to 1, its write count reads 512, and the producer moves to the other half.
- R4: A producer end flag together with an accepted byte closes the half after that byte. An end flag with no byte closes the fill half if it holds at least one byte and is not already closed. An end flag on a half with zero count changes nothing.
- R5: The consumer is ready only while the half it drains is closed. Its address is that half's base plus the read count. The last byte read empties the half, sets both counts to zero, and moves the consumer to the other half.
- R6: While the half the producer would fill is still closed, the producer's ready flag is 0 and its strobes change no count.
- R7: With direction 0, `usb_*` is the producer and `ata_*` is the consumer. With direction 1 the roles swap. An end flag from the consumer side is ignored.
- R8: A change of `dir_i` is applied only in a cycle where both halves are empty. In that cycle the producer is not ready. From the next cycle `dir_o` shows the new value, all counts are zero, and both pointers are on half A.
- R9: A write count never exceeds 512, and a read count never exceeds the write count of its half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Requested flow direction (0: USB to ATA, 1: ATA to USB) |
| usb_stb_i | input | 1 | USB side moves one byte this cycle |
| usb_end_i | input | 1 | USB side closes the current half (used when producing) |
| ata_stb_i | input | 1 | ATA side moves one byte this cycle |
| ata_end_i | input | 1 | ATA side closes the current half (used when producing) |
| dir_o | output | 1 | Direction in effect |
| usb_rdy_o | output | 1 | USB side may move a byte this cycle |
| usb_addr_o | output | 11 | SRAM byte address for the USB side |
| ata_rdy_o | output | 1 | ATA side may move a byte this cycle |
| ata_addr_o | output | 11 | SRAM byte address for the ATA side |
| half_full_o | output | 2 | Closed halves awaiting drain (bit 0 = A, bit 1 = B) |
| wcnt_a_o | output | 10 | Bytes written into half A |
| rcnt_a_o | output | 10 | Bytes read out of half A |
| wcnt_b_o | output | 10 | Bytes written into half B |
| rcnt_b_o | output | 10 | Bytes read out of half B |

## Verification
The properties assume only that the strobes, the end flags and `dir_i` carry known values from the first clock after reset. Strobes may come at any time, including while a side is not ready. The properties do not rely on the sides waiting for the ready flag, because a byte offered without ready must simply be dropped. The stimulus drives every input to a defined level from time zero and changes inputs only on the falling clock edge. It deliberately offers bytes while the producer is stalled, raises end flags on empty halves and from the consumer side, and requests a direction change while data is still held, so these cases fall within what the properties allow.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} half_e;

  function automatic half_e other_half(input half_e h);
    return (h == HALF_A) ? HALF_B : HALF_A;
  endfunction
endpackage

// File: rtl/pp_half.sv
module pp_half #(
  parameter int                BUF_BYTES = 512,
  parameter int                CNT_W     = 10,
  parameter int                ADDR_W    = 11,
  parameter logic [ADDR_W-1:0] BASE      = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              seal_i,
  input  logic              rd_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              top_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  wcnt_o,
  output logic [CNT_W-1:0]  rcnt_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o
);
  logic             full_q;
  logic [CNT_W-1:0] wcnt_q, rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else if (clr_i) begin
      full_q <= 1'b0;
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else if (rd_i) begin
      // a closed half is only ever read; the final read frees it
      if (last_o) begin
        full_q <= 1'b0;
        wcnt_q <= '0;
        rcnt_q <= '0;
      end else begin
        rcnt_q <= rcnt_q + 1'b1;
      end
    end else begin
      if (wr_i)   wcnt_q <= wcnt_q + 1'b1;
      if (seal_i) full_q <= 1'b1;
    end
  end

  assign full_o  = full_q;
  assign empty_o = !full_q && (wcnt_q == '0);
  assign top_o   = (wcnt_q == CNT_W'(BUF_BYTES - 1));
  assign last_o  = ((rcnt_q + 1'b1) == wcnt_q);
  assign wcnt_o  = wcnt_q;
  assign rcnt_o  = rcnt_q;
  assign waddr_o = BASE + ADDR_W'(wcnt_q);
  assign raddr_o = BASE + ADDR_W'(rcnt_q);
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_i,
  input  logic [1:0] full_i,
  input  logic [1:0] empty_i,
  input  logic [1:0] top_i,
  input  logic [1:0] last_i,
  input  logic       prod_stb_i,
  input  logic       prod_end_i,
  input  logic       cons_stb_i,
  output logic       dir_o,
  output half_e      fill_o,
  output half_e      drain_o,
  output logic       apply_o,
  output logic       prod_rdy_o,
  output logic       cons_rdy_o,
  output logic [1:0] wr_o,
  output logic [1:0] seal_o,
  output logic [1:0] rd_o
);
  logic  dir_q;
  half_e fill_q, drain_q;
  logic  prod_acc, cons_acc, seal_now, drain_done;

  assign apply_o    = (dir_i != dir_q) && (&empty_i);
  assign prod_rdy_o = !full_i[fill_q] && !apply_o;
  assign cons_rdy_o = full_i[drain_q];
  assign prod_acc   = prod_stb_i && prod_rdy_o;
  assign cons_acc   = cons_stb_i && cons_rdy_o;

  // early close needs a non-empty, still-open fill half
  always_comb begin
    if (prod_acc) seal_now = prod_end_i || top_i[fill_q];
    else          seal_now = prod_end_i && !full_i[fill_q] && !empty_i[fill_q];
  end

  assign drain_done = cons_acc && last_i[drain_q];

  for (genvar g = 0; g < 2; g++) begin : g_sel
    localparam half_e H = (g == 0) ? HALF_A : HALF_B;
    assign wr_o[g]   = prod_acc && (fill_q == H);
    assign seal_o[g] = seal_now && (fill_q == H);
    assign rd_o[g]   = cons_acc && (drain_q == H);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= 1'b0;
      fill_q  <= HALF_A;
      drain_q <= HALF_A;
    end else if (apply_o) begin
      dir_q   <= dir_i;
      fill_q  <= HALF_A;
      drain_q <= HALF_A;
    end else begin
      if (seal_now)   fill_q  <= other_half(fill_q);
      if (drain_done) drain_q <= other_half(drain_q);
    end
  end

  assign dir_o   = dir_q;
  assign fill_o  = fill_q;
  assign drain_o = drain_q;
endmodule

// File: rtl/pp_route.sv
module pp_route #(
  parameter int ADDR_W = 11
) (
  input  logic              dir_i,
  input  logic              usb_stb_i,
  input  logic              usb_end_i,
  input  logic              ata_stb_i,
  input  logic              ata_end_i,
  input  logic              prod_rdy_i,
  input  logic [ADDR_W-1:0] prod_addr_i,
  input  logic              cons_rdy_i,
  input  logic [ADDR_W-1:0] cons_addr_i,
  output logic              prod_stb_o,
  output logic              prod_end_o,
  output logic              cons_stb_o,
  output logic              usb_rdy_o,
  output logic [ADDR_W-1:0] usb_addr_o,
  output logic              ata_rdy_o,
  output logic [ADDR_W-1:0] ata_addr_o
);
  // consumer end flag is dropped here by design
  always_comb begin
    if (dir_i) begin
      prod_stb_o = ata_stb_i;
      prod_end_o = ata_end_i;
      cons_stb_o = usb_stb_i;
      ata_rdy_o  = prod_rdy_i;
      ata_addr_o = prod_addr_i;
      usb_rdy_o  = cons_rdy_i;
      usb_addr_o = cons_addr_i;
    end else begin
      prod_stb_o = usb_stb_i;
      prod_end_o = usb_end_i;
      cons_stb_o = ata_stb_i;
      usb_rdy_o  = prod_rdy_i;
      usb_addr_o = prod_addr_i;
      ata_rdy_o  = cons_rdy_i;
      ata_addr_o = cons_addr_i;
    end
  end
endmodule

// File: rtl/pp_buf_mgr.sv
module pp_buf_mgr
  import pp_pkg::*;
#(
  parameter int                BUF_BYTES = 512,
  parameter int                ADDR_W    = 11,
  parameter logic [ADDR_W-1:0] BASE_A    = 11'h100,
  parameter logic [ADDR_W-1:0] BASE_B    = 11'h300,
  localparam int               CNT_W     = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              usb_stb_i,
  input  logic              usb_end_i,
  input  logic              ata_stb_i,
  input  logic              ata_end_i,
  output logic              dir_o,
  output logic              usb_rdy_o,
  output logic [ADDR_W-1:0] usb_addr_o,
  output logic              ata_rdy_o,
  output logic [ADDR_W-1:0] ata_addr_o,
  output logic [1:0]        half_full_o,
  output logic [CNT_W-1:0]  wcnt_a_o,
  output logic [CNT_W-1:0]  rcnt_a_o,
  output logic [CNT_W-1:0]  wcnt_b_o,
  output logic [CNT_W-1:0]  rcnt_b_o
);
  logic [1:0]        full, empty, top, last, wr, seal, rd;
  logic [CNT_W-1:0]  wcnt [2];
  logic [CNT_W-1:0]  rcnt [2];
  logic [ADDR_W-1:0] waddr [2];
  logic [ADDR_W-1:0] raddr [2];
  logic              apply, prod_rdy, cons_rdy, prod_stb, prod_end, cons_stb;
  half_e             fill, drain;

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam logic [ADDR_W-1:0] BASE = (g == 0) ? BASE_A : BASE_B;
    pp_half #(
      .BUF_BYTES (BUF_BYTES),
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .BASE      (BASE)
    ) i_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (apply),
      .wr_i    (wr[g]),
      .seal_i  (seal[g]),
      .rd_i    (rd[g]),
      .full_o  (full[g]),
      .empty_o (empty[g]),
      .top_o   (top[g]),
      .last_o  (last[g]),
      .wcnt_o  (wcnt[g]),
      .rcnt_o  (rcnt[g]),
      .waddr_o (waddr[g]),
      .raddr_o (raddr[g])
    );
  end

  pp_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_i      (dir_i),
    .full_i     (full),
    .empty_i    (empty),
    .top_i      (top),
    .last_i     (last),
    .prod_stb_i (prod_stb),
    .prod_end_i (prod_end),
    .cons_stb_i (cons_stb),
    .dir_o      (dir_o),
    .fill_o     (fill),
    .drain_o    (drain),
    .apply_o    (apply),
    .prod_rdy_o (prod_rdy),
    .cons_rdy_o (cons_rdy),
    .wr_o       (wr),
    .seal_o     (seal),
    .rd_o       (rd)
  );

  pp_route #(.ADDR_W(ADDR_W)) i_route (
    .dir_i       (dir_o),
    .usb_stb_i   (usb_stb_i),
    .usb_end_i   (usb_end_i),
    .ata_stb_i   (ata_stb_i),
    .ata_end_i   (ata_end_i),
    .prod_rdy_i  (prod_rdy),
    .prod_addr_i (waddr[fill]),
    .cons_rdy_i  (cons_rdy),
    .cons_addr_i (raddr[drain]),
    .prod_stb_o  (prod_stb),
    .prod_end_o  (prod_end),
    .cons_stb_o  (cons_stb),
    .usb_rdy_o   (usb_rdy_o),
    .usb_addr_o  (usb_addr_o),
    .ata_rdy_o   (ata_rdy_o),
    .ata_addr_o  (ata_addr_o)
  );

  assign half_full_o = full;
  assign wcnt_a_o    = wcnt[0];
  assign rcnt_a_o    = rcnt[0];
  assign wcnt_b_o    = wcnt[1];
  assign rcnt_b_o    = rcnt[1];
endmodule

// File: rtl/pp_buf_mgr_chk.sv
module pp_buf_mgr_chk #(
  parameter int  BUF_BYTES = 512,
  localparam int CNT_W     = $clog2(BUF_BYTES) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dir_o,
  input logic             usb_rdy_o,
  input logic             ata_rdy_o,
  input logic [1:0]       half_full_o,
  input logic [CNT_W-1:0] wcnt_a_o,
  input logic [CNT_W-1:0] rcnt_a_o,
  input logic [CNT_W-1:0] wcnt_b_o,
  input logic [CNT_W-1:0] rcnt_b_o
);
  a_r9_cap_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_a_o <= CNT_W'(BUF_BYTES));
  a_r9_cap_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_b_o <= CNT_W'(BUF_BYTES));
  a_r9_rd_le_wr_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcnt_a_o <= wcnt_a_o);
  a_r9_rd_le_wr_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcnt_b_o <= wcnt_b_o);
  a_r6_stall_both_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&half_full_o) |-> !(dir_o ? ata_rdy_o : usb_rdy_o));
  a_r5_cons_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o ? usb_rdy_o : ata_rdy_o) |-> (|half_full_o));
  a_r8_dir_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_o) |-> ($past(half_full_o) == 2'b00 && $past(wcnt_a_o) == '0
                         && $past(wcnt_b_o) == '0));
  a_r3_seal_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(half_full_o[0]) |-> (wcnt_a_o != '0));
  a_r5_drain_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(half_full_o[0]) |-> (wcnt_a_o == '0 && rcnt_a_o == '0));
endmodule

bind pp_buf_mgr pp_buf_mgr_chk i_chk (.*);

// File: tb/test_pp_buf_mgr.sv
module test_pp_buf_mgr;
  localparam int CLK_T = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dir_i = 1'b0, usb_stb_i = 1'b0, usb_end_i = 1'b0;
  logic        ata_stb_i = 1'b0, ata_end_i = 1'b0;
  logic        dir_o, usb_rdy_o, ata_rdy_o;
  logic [10:0] usb_addr_o, ata_addr_o;
  logic [1:0]  half_full_o;
  logic [9:0]  wcnt_a_o, rcnt_a_o, wcnt_b_o, rcnt_b_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk_i = ~clk_i;

  pp_buf_mgr i_pp_buf_mgr (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        dir, us, ue, as, ae;
    logic        e_dir, e_ur;
    logic [10:0] e_ua;
    logic        e_ar;
    logic [10:0] e_aa;
    logic [1:0]  e_full;
  } vec_t;

  // req, dir,us,ue,as,ae, e_dir,e_ur,e_ua, e_ar,e_aa, e_full
  localparam vec_t VEC [20] = '{
    '{4'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,11'h100, 1'b0,11'h100, 2'b00}, // R1 idle
    '{4'd2, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,11'h100, 1'b0,11'h100, 2'b00}, // R2 byte 0 to A
    '{4'd4, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,11'h101, 1'b0,11'h100, 2'b00}, // R4 end with byte
    '{4'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,11'h300, 1'b1,11'h100, 2'b01}, // R2 fill moves to B
    '{4'd5, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,11'h300, 1'b1,11'h100, 2'b01}, // R5 read A0
    '{4'd5, 1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,11'h300, 1'b1,11'h101, 2'b01}, // R5 read last, close B
    '{4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,11'h100, 1'b1,11'h300, 2'b10}, // R5 drain at B
    '{4'd4, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,11'h100, 1'b1,11'h300, 2'b10}, // R4 end on empty A
    '{4'd4, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,11'h100, 1'b1,11'h300, 2'b10}, // R4 A not closed
    '{4'd7, 1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,11'h100, 1'b1,11'h300, 2'b10}, // R7 consumer end ignored
    '{4'd7, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,11'h100, 1'b0,11'h100, 2'b00}, // R7 A still open
    '{4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,11'h100, 1'b0,11'h100, 2'b00}, // R8 apply cycle
    '{4'd7, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,11'h100, 1'b1,11'h100, 2'b00}, // R7 ATA produces
    '{4'd7, 1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,11'h100, 1'b1,11'h100, 2'b00}, // R7 ATA byte 0
    '{4'd4, 1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,11'h100, 1'b1,11'h101, 2'b00}, // R4 end alone, count 1
    '{4'd4, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,11'h100, 1'b1,11'h300, 2'b01}, // R4 A closed
    '{4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,11'h100, 1'b1,11'h300, 2'b01}, // R8 held, data in A
    '{4'd8, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,11'h100, 1'b1,11'h300, 2'b01}, // R8 USB drains A
    '{4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,11'h300, 1'b0,11'h300, 2'b00}, // R8 apply, fill on B
    '{4'd8, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,11'h100, 1'b0,11'h100, 2'b00}  // R8 pointers back to A
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic d, us, ue, as, ae);
    dir_i = d; usb_stb_i = us; usb_end_i = ue; ata_stb_i = as; ata_end_i = ae;
  endtask

  task automatic check_r1();
    chk("R1 dir",      32'(dir_o), 32'd0);
    chk("R1 usb_rdy",  32'(usb_rdy_o), 32'd1);
    chk("R1 usb_addr", 32'(usb_addr_o), 32'h100);
    chk("R1 ata_rdy",  32'(ata_rdy_o), 32'd0);
    chk("R1 ata_addr", 32'(ata_addr_o), 32'h100);
    chk("R1 full",     32'(half_full_o), 32'd0);
    chk("R1 counts",   {wcnt_a_o, rcnt_a_o, wcnt_b_o[1:0]}, 32'd0);
    chk("R1 counts_b", 32'({wcnt_b_o, rcnt_b_o}), 32'd0);
  endtask

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_r1();

    // vector table
    foreach (VEC[i]) begin
      vec_t v;
      v = VEC[i];
      drive(v.dir, v.us, v.ue, v.as, v.ae);
      #1;
      n_chk++;
      if ({dir_o, usb_rdy_o, usb_addr_o, ata_rdy_o, ata_addr_o, half_full_o} !==
          {v.e_dir, v.e_ur, v.e_ua, v.e_ar, v.e_aa, v.e_full}) begin
        n_bad++;
        $display("FAIL R%0d vector %0d actual=%0h/%0h/%0h/%0h/%0h/%0h expected=%0h/%0h/%0h/%0h/%0h/%0h",
                 v.req, i, dir_o, usb_rdy_o, usb_addr_o, ata_rdy_o, ata_addr_o, half_full_o,
                 v.e_dir, v.e_ur, v.e_ua, v.e_ar, v.e_aa, v.e_full);
      end
      @(negedge clk_i);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R3: fill A to 512 bytes
    for (int i = 0; i < 512; i++) begin
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      #1;
      if (i == 511) chk("R2 last A address", 32'(usb_addr_o), 32'h2FF);
      @(negedge clk_i);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R3 A closed", 32'(half_full_o), 32'b01);
    chk("R3 A count", 32'(wcnt_a_o), 32'd512);
    chk("R3 fill on B", 32'(usb_addr_o), 32'h300);
    chk("R3 producer ready", 32'(usb_rdy_o), 32'd1);

    // fill B
    @(negedge clk_i);
    for (int i = 0; i < 512; i++) begin
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      #1;
      if (i == 511) chk("R2 last B address", 32'(usb_addr_o), 32'h4FF);
      @(negedge clk_i);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R6 both closed", 32'(half_full_o), 32'b11);
    chk("R6 producer stalled", 32'(usb_rdy_o), 32'd0);

    // R6: strobe while stalled
    @(negedge clk_i);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R6 A count kept", 32'(wcnt_a_o), 32'd512);
    chk("R6 B count kept", 32'(wcnt_b_o), 32'd512);
    chk("R6 consumer addr", 32'(ata_addr_o), 32'h100);

    // R5: drain A
    @(negedge clk_i);
    for (int i = 0; i < 512; i++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      #1;
      if (i == 300) begin
        chk("R5 read count", 32'(rcnt_a_o), 32'd300);
        chk("R5 read address", 32'(ata_addr_o), 32'h22C);
      end
      @(negedge clk_i);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R5 A emptied", 32'({wcnt_a_o, rcnt_a_o}), 32'd0);
    chk("R5 full flags", 32'(half_full_o), 32'b10);
    chk("R5 producer back on A", 32'({usb_rdy_o, usb_addr_o}), {20'd0, 1'b1, 11'h100});
    chk("R5 drain on B", 32'(ata_addr_o), 32'h300);

    // R8: request 1 while B holds data, then drain B
    @(negedge clk_i);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    #1;
    chk("R8 no early change", 32'(dir_o), 32'd0);
    @(negedge clk_i);
    for (int i = 0; i < 512; i++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      @(negedge clk_i);
    end
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R8 apply cycle dir", 32'(dir_o), 32'd0);
    chk("R8 apply cycle no producer", 32'(usb_rdy_o), 32'd0);
    @(negedge clk_i);
    #1;
    chk("R8 dir applied", 32'(dir_o), 32'd1);
    chk("R7 ATA producer", 32'({ata_rdy_o, ata_addr_o}), {20'd0, 1'b1, 11'h100});
    chk("R7 USB consumer idle", 32'(usb_rdy_o), 32'd0);

    // R1: reset mid-run
    @(negedge clk_i);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk_i);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    #1;
    check_r1();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule